// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

A small synchronous static memory built to keep its shared data bus busy on every clock cycle, whatever the mix of reads and writes. Each command (address, read/write select, byte enables and chip enables) is captured on a rising clock edge. The data for a write is not taken with its address; it arrives a fixed number of edges later, in the same bus slot a read issued at that point would use. A write placed right after a read therefore never collides with the read's returning data, and no idle cycle is ever needed.

Two timing modes are chosen by a mode input. In registered (pipelined) mode, read data leaves through an output register and write data lags its address by two edges. In flow-through mode, read data comes straight from the array and write data lags by one edge. In registered mode a read may name an address whose write has not yet reached the array. Such a read returns the in-flight bytes, merged per byte with the stored word. An active-high output enable gates the bus drive combinationally, without waiting for a clock edge. The bidirectional bus appears as separate data-in, data-out and drive-enable signals.

Top module: `ztSram`

## Requirements
- R1: A command is accepted on a rising edge only when `ceA`, `ceB` and `ceC` are all 1. A cycle with any of them 0 is deselected: it writes nothing and causes no bus drive.
- R2: Reads and writes to any addresses may be issued on consecutive edges, in any order, with no idle cycle between them. Every accepted read returns correct data.
- R3: In registered mode (`flowThru`=0), the data of a write accepted at edge k is taken from `dIn` at edge k+2.
- R4: In flow-through mode (`flowThru`=1), the data of a write accepted at edge k is taken from `dIn` at edge k+1.
- R5: In registered mode, a read accepted at edge k drives its word on `dOut` with `dOe`=1 from edge k+1 until edge k+2.
- R6: In flow-through mode, a read accepted at edge k drives its word on `dOut` with `dOe`=1 from edge k until edge k+1.
- R7: With `outEn`=0, `dOe` is 0 at once, without waiting for a clock edge. Raising `outEn` again restores the drive of a read data cycle at once.
- R8: `dOe` is 0 in every cycle that is not the data cycle of an accepted read, including the data cycle of a write.
- R9: Byte b occupies `dIn`/`dOut` bits [9b+8:9b]. A write with `byteEn[b]`=1 updates that byte, and a write with `byteEn[b]`=0 leaves that byte unchanged.
- R10: In registered mode, a read accepted one edge after a write to the same address returns the write's enabled bytes from `dIn`, and the stored bytes for the rest.
- R11: While `rstN` is 0 and after its release, no pending command survives, and `dOe` is 0 until a new read reaches its data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| flowThru | input | 1 | 1 = flow-through timing, 0 = registered timing; changed only while idle |
| ceA | input | 1 | Chip enable, active high |
| ceB | input | 1 | Chip enable, active high |
| ceC | input | 1 | Chip enable, active high |
| wrSel | input | 1 | 1 = write command, 0 = read command |
| addr | input | ADDR_W | Word address |
| byteEn | input | BYTES | Per-byte write enables, active high |
| dIn | input | BYTES*BYTE_W | Bus input (write data) |
| outEn | input | 1 | Output enable, active high, combinational |
| dOut | output | BYTES*BYTE_W | Bus output (read data) |
| dOe | output | 1 | Bus drive enable |

## Verification
The main traffic is a seeded random stream over only eight addresses. Read-after-write hits at lag one and lag two are therefore frequent, and they show whether the forwarding merge or the array itself supplies each byte. Random byte masks, including the empty mask, separate correct partial writes from whole-word writes. Random deselects, with one chip enable dropped, separate honoured commands from ignored ones. Random gaps in the output enable check that the drive is gated without a clock edge. Each mode is also given directed read-write-read and write-then-read runs on one address. These show whether the write data slot sits at the right lag, and whether a read that follows a write sees the new bytes or stale ones.

// File: rtl/ztSramPkg.sv
package ztSramPkg;

  // Strobes from the command pipeline to the storage datapath.
  typedef struct packed {
    logic wrEn;   // commit dIn into the array at this edge
    logic ldOut;  // capture the merged read word into the output register
    logic drive;  // bus drive enable, already gated by outEn
    logic flow;   // flow-through timing selected
  } strobes_t;

endpackage

// File: rtl/zsCtrl.sv
module zsCtrl
  import ztSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  logic              ceA,
  input  logic              ceB,
  input  logic              ceC,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byteEn,
  input  logic              outEn,
  output strobes_t          strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTES-1:0]  wrBe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [BYTES-1:0]  fwdBe
);

  logic              sel;
  logic              vld1, isWr1, vld2, isWr2;
  logic [ADDR_W-1:0] adr1, adr2;
  logic [BYTES-1:0]  be1, be2;
  logic [1:0]        upCnt;

  assign sel = ceA & ceB & ceC;

  // Command stages: stage 1 holds the command of the last edge, stage 2 the one before.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld1  <= 1'b0;
      isWr1 <= 1'b0;
      vld2  <= 1'b0;
      isWr2 <= 1'b0;
    end else begin
      vld1  <= sel;
      isWr1 <= wrSel;
      vld2  <= vld1;
      isWr2 <= isWr1;
    end
  end

  always_ff @(posedge clk) begin
    adr1 <= addr;
    be1  <= byteEn;
    adr2 <= adr1;
    be2  <= be1;
  end

  // Edges since reset release, saturating; used only to qualify history checks.
  always_ff @(posedge clk) begin
    if (!rstN)               upCnt <= 2'd0;
    else if (upCnt != 2'd3)  upCnt <= upCnt + 2'd1;
  end

  always_comb begin
    strb.flow  = flowThru;
    strb.wrEn  = flowThru ? (vld1 & isWr1) : (vld2 & isWr2);
    wrAddr     = flowThru ? adr1 : adr2;
    wrBe       = flowThru ? be1 : be2;
    rdAddr     = adr1;
    strb.ldOut = ~flowThru & vld1 & ~isWr1;
    fwdBe      = (!flowThru && vld2 && isWr2 && adr2 == adr1) ? be2 : '0;
    strb.drive = outEn & (flowThru ? (vld1 & ~isWr1) : (vld2 & ~isWr2));
  end

  AST_WR_LAG_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && strb.wrEn && !flowThru) |-> $past(sel && wrSel, 2)); // R3

  AST_WR_LAG_FLOW: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && strb.wrEn && flowThru) |-> $past(sel && wrSel)); // R4

  AST_RD_PIPE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && outEn && !flowThru && !$past(flowThru) && !$past(flowThru, 2)
     && $past(sel && !wrSel, 2)) |-> strb.drive); // R5

  AST_RD_FLOW_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && outEn && flowThru && $past(flowThru) && $past(sel && !wrSel))
    |-> strb.drive); // R6

  AST_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !strb.drive); // R8

endmodule

// File: rtl/zsPath.sv
module zsPath
  import ztSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTES-1:0]  wrBe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BYTES-1:0]  fwdBe,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] outReg;

  // One storage lane per byte, each with its own write enable.
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.wrEn && wrBe[b]) lane[wrAddr] <= dIn[b*BYTE_W +: BYTE_W];
    end

    // A pending write to the read address wins byte by byte over stored contents.
    assign merged[b*BYTE_W +: BYTE_W] =
      fwdBe[b] ? dIn[b*BYTE_W +: BYTE_W] : lane[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (strb.ldOut) outReg <= merged;
  end

  assign dOut = strb.flow ? merged : outReg;

endmodule

// File: rtl/ztSram.sv
module ztSram
  import ztSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  logic              ceA,
  input  logic              ceB,
  input  logic              ceC,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byteEn,
  input  logic [DATA_W-1:0] dIn,
  input  logic              outEn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);

  strobes_t          strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [BYTES-1:0]  wrBe, fwdBe;

  zsCtrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .flowThru(flowThru),
    .ceA(ceA), .ceB(ceB), .ceC(ceC), .wrSel(wrSel),
    .addr(addr), .byteEn(byteEn), .outEn(outEn),
    .strb(strb), .wrAddr(wrAddr), .wrBe(wrBe),
    .rdAddr(rdAddr), .fwdBe(fwdBe)
  );

  zsPath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) i_path (
    .clk(clk), .strb(strb), .wrAddr(wrAddr), .wrBe(wrBe),
    .rdAddr(rdAddr), .fwdBe(fwdBe), .dIn(dIn), .dOut(dOut)
  );

  assign dOe = strb.drive;

endmodule

// File: tb/test_ztSram.sv
`timescale 1ns/1ps
module test_ztSram;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 18;
  localparam int HN = 2048;

  logic          clk = 1'b0;
  logic          rstN, flowThru, ceA, ceB, ceC, wrSel, outEn, dOe;
  logic [AW-1:0] addr;
  logic [NB-1:0] byteEn;
  logic [DW-1:0] dIn, dOut;

  int checks = 0;
  int errors = 0;
  int t = 0;

  bit            hv [HN];
  bit            hw [HN];
  logic [AW-1:0] ha [HN];
  logic [NB-1:0] hbe[HN];
  logic [DW-1:0] hd [HN];
  logic [DW-1:0] model [1 << AW];

  always #5 clk = ~clk;

  ztSram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(9)) i_ztSram (
    .clk(clk), .rstN(rstN), .flowThru(flowThru), .ceA(ceA), .ceB(ceB), .ceC(ceC),
    .wrSel(wrSel), .addr(addr), .byteEn(byteEn), .dIn(dIn), .outEn(outEn),
    .dOut(dOut), .dOe(dOe)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0d actual=%h expected=%h", req, t, act, exp);
    end
  endtask

  // Byte-masked update of a word, from the requirements (R9).
  function automatic logic [DW-1:0] maskMerge(input logic [DW-1:0] old,
      input logic [DW-1:0] nw, input logic [NB-1:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (be[b]) r[b*9 +: 9] = nw[b*9 +: 9];
    return r;
  endfunction

  // One bus cycle: check the data slot ending at edge t, drive the command of edge t.
  task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                      input logic [NB-1:0] be, input logic [DW-1:0] d, input bit oe);
    int lat = flowThru ? 1 : 2;
    int e   = t - lat;
    int ld;
    @(negedge clk);
    if (e >= 0 && hv[e] && !hw[e] && outEn) begin
      string lbl;
      if (flowThru) lbl = "R6 R1 R2 R4 R9";
      else if (e >= 1 && hv[e-1] && hw[e-1] && ha[e-1] == ha[e]) lbl = "R10 R2 R3";
      else lbl = "R5 R1 R2 R3 R9";
      chk(dOe == 1'b1, lbl, {17'd0, dOe}, 18'd1);
      chk(dOut == model[ha[e]], lbl, dOut, model[ha[e]]);
      if ((t % 5) == 0) begin
        outEn = 1'b0;
        #1 chk(dOe == 1'b0, "R7", {17'd0, dOe}, 18'd0);
        outEn = 1'b1;
        #1 chk(dOe == 1'b1, "R7", {17'd0, dOe}, 18'd1);
      end
    end else begin
      chk(dOe == 1'b0, outEn ? "R8 R1" : "R7", {17'd0, dOe}, 18'd0);
    end
    hv[t] = v; hw[t] = w; ha[t] = a; hbe[t] = be; hd[t] = d;
    {ceA, ceB, ceC} = 3'b111;
    if (!v) begin
      case ($urandom % 3)
        0: ceA = 1'b0;
        1: ceB = 1'b0;
        default: ceC = 1'b0;
      endcase
    end
    wrSel = w; addr = a; byteEn = be; outEn = oe;
    ld = t - lat;
    if (ld >= 0 && hv[ld] && hw[ld]) dIn = hd[ld];
    else dIn = DW'($urandom);
    @(posedge clk);
    if (ld >= 0 && hv[ld] && hw[ld]) model[ha[ld]] = maskMerge(model[ha[ld]], hd[ld], hbe[ld]);
    t++;
  endtask

  task automatic randRun(input int n);
    for (int i = 0; i < n; i++)
      step(($urandom % 8) != 0, $urandom % 2, AW'($urandom % 8), NB'($urandom),
           DW'($urandom), ($urandom % 10) != 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, 1'b1);
  endtask

  task automatic directed();
    // write then read same address, partial bytes (R10 in registered mode)
    step(1, 1, 6'd3, 2'b01, 18'h1ABCD, 1);
    step(1, 0, 6'd3, 2'b00, 18'h0, 1);
    // read-write-read on one address, no idle (R2)
    step(1, 0, 6'd5, 2'b00, 18'h0, 1);
    step(1, 1, 6'd5, 2'b10, 18'h2F0F0, 1);
    step(1, 0, 6'd5, 2'b00, 18'h0, 1);
    step(1, 1, 6'd5, 2'b00, 18'h3FFFF, 1); // empty mask changes nothing (R9)
    step(1, 0, 6'd5, 2'b00, 18'h0, 1);
    // deselected write must not land (R1)
    step(0, 1, 6'd2, 2'b11, 18'h15555, 1);
    step(1, 0, 6'd2, 2'b00, 18'h0, 1);
    idle(3);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; flowThru = 1'b0; {ceA, ceB, ceC} = 3'b000;
    wrSel = 1'b0; addr = '0; byteEn = '0; dIn = '0; outEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dOe == 1'b0, "R11", {17'd0, dOe}, 18'd0);
    rstN = 1'b1;
    // preload the eight addresses used by the random runs
    for (int a = 0; a < 8; a++) step(1, 1, AW'(a), 2'b11, DW'($urandom), 1);
    idle(2);
    chk(dOe == 1'b0, "R11", {17'd0, dOe}, 18'd0);
    directed();
    randRun(400);
    idle(3);
    @(negedge clk);
    flowThru = 1'b1;
    idle(2);
    directed();
    randRun(400);
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired at t=%0d", t);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule